// File: doc/BRIEF.md
# Belt Execute Unit

This block is the execute stage of a small single-issue belt processor. Each instruction names up to two operands by their age on the belt, counted from the most recent value, and never names where a result goes. The unit decodes the 16-bit word and drives the two operand positions to an external belt store. It reads the returned values and computes the result in the same cycle. The result leaves on a drop port, and the store pushes it onto the front of the belt at the clock edge that accepts the instruction.

A carry-producing add returns two values in one step. A load-immediate form carries a signed constant in place of the two position fields. An opcode outside the defined set produces no drop and raises a status flag. Because the whole instruction completes in its acceptance cycle, the next instruction's position reads already see the new front of the belt.

Top module: `belt_exec_unit`

## Requirements
- R1: The instruction word holds the opcode in bits [15:10], operand position A in bits [9:5] and operand position B in bits [4:0]. `rd_pos_a` and `rd_pos_b` carry those two fields.
- R2: ADD (opcode 1) drops A+B and SUB (opcode 2) drops A−B, each as a single value (`drop_count`=1, value on `drop_val0`), with 32-bit wraparound.
- R3: AND (3), OR (4) and XOR (5) drop the bitwise result of A and B. SHL (6) drops A shifted left by the low 5 bits of B. Each of these is a single drop.
- R4: ADDC (opcode 8) drops two values in one cycle (`drop_count`=2). `drop_val1` holds the carry out of A+B as 0 or 1 and ends at belt position 1. `drop_val0` holds the 32-bit sum and ends at position 0.
- R5: LDI (opcode 16) drops bits [9:0] sign-extended to 32 bits as a single value. The belt read data has no effect on the dropped value.
- R6: An accepted instruction with any other opcode drops nothing. `illegal_flag` is high in the cycle after it and stays high until the next accepted defined instruction clears it.
- R7: No drop occurs in a cycle where `in_valid` and `in_ready` are not both high.
- R8: While `rst_n` is low, `in_ready`, `drop_valid` and `illegal_flag` are low. `in_ready` is high from the first cycle after reset is released.
- R9: Every instruction completes in its acceptance cycle, so an instruction accepted in the next cycle reads the values dropped by its predecessor at positions 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Unit accepts an instruction this cycle |
| in_instr | input | 16 | Instruction word |
| rd_pos_a | output | 5 | Belt position read for operand A |
| rd_pos_b | output | 5 | Belt position read for operand B |
| rd_data_a | input | 32 | Belt value at `rd_pos_a` |
| rd_data_b | input | 32 | Belt value at `rd_pos_b` |
| drop_valid | output | 1 | Belt store must push drops at this edge |
| drop_count | output | 2 | Number of values dropped (1 or 2) |
| drop_val0 | output | 32 | Value ending at belt position 0 |
| drop_val1 | output | 32 | Value ending at belt position 1 when two are dropped |
| illegal_flag | output | 1 | Last accepted instruction had an undefined opcode |

## Verification
The flag update and the dual drop can share a cycle. An ADDC accepted right after an undefined opcode must push two values while clearing the flag raised one cycle earlier. The bench provokes this with back-to-back illegal/ADDC pairs, both directed and scattered through the random stream. It judges both drop ports against its own belt model in the acceptance cycle and the flag one edge later. The following instruction reads positions 0 and 1, which confirms that both values landed in the right order.

// File: rtl/belt_exec_pkg.sv
// Package: shared opcode values and decode control types for the belt
// execute unit. Assumes a 6-bit opcode field at the top of the word.
package belt_exec_pkg;

    localparam int OPC_W = 6;

    typedef enum logic [OPC_W-1:0] {
        OP_ADD  = 6'd1,
        OP_SUB  = 6'd2,
        OP_AND  = 6'd3,
        OP_OR   = 6'd4,
        OP_XOR  = 6'd5,
        OP_SHL  = 6'd6,
        OP_ADDC = 6'd8,
        OP_LDI  = 6'd16
    } belt_op_e;

    typedef enum logic [2:0] {
        FN_ADD,
        FN_SUB,
        FN_AND,
        FN_OR,
        FN_XOR,
        FN_SHL,
        FN_PASS
    } alu_fn_e;

    typedef struct packed {
        logic    legal;    // opcode is defined
        logic    dual;     // two results are dropped
        logic    use_imm;  // operand B replaced by the constant
        alu_fn_e fn;       // ALU function
    } dec_ctl_t;

endpackage

// File: rtl/belt_exec_decode.sv
// Module: belt_exec_decode
// Splits an instruction word into opcode, two position fields and the
// immediate, and maps the opcode onto ALU control. Purely combinational.
// Assumes the opcode occupies the top bits and the positions the rest.
module belt_exec_decode
    import belt_exec_pkg::*;
#(
    parameter int POS_W = 5
) (
    input  logic [OPC_W+2*POS_W-1:0] instr,
    output logic [POS_W-1:0]         pos_a,
    output logic [POS_W-1:0]         pos_b,
    output logic [2*POS_W-1:0]       imm,
    output dec_ctl_t                 ctl
);

    localparam int INSTR_W = OPC_W + 2 * POS_W;

    logic [OPC_W-1:0] opc;

    // Field extraction from the fixed word layout
    always_comb begin
        opc   = instr[INSTR_W-1 -: OPC_W];
        pos_a = instr[2*POS_W-1 -: POS_W];
        pos_b = instr[POS_W-1:0];
        imm   = instr[2*POS_W-1:0];
    end

    // Opcode to control mapping; unknown codes leave legal low
    always_comb begin
        ctl = '{legal: 1'b1, dual: 1'b0, use_imm: 1'b0, fn: FN_ADD};
        unique case (opc)
            OP_ADD:  ctl.fn = FN_ADD;
            OP_SUB:  ctl.fn = FN_SUB;
            OP_AND:  ctl.fn = FN_AND;
            OP_OR:   ctl.fn = FN_OR;
            OP_XOR:  ctl.fn = FN_XOR;
            OP_SHL:  ctl.fn = FN_SHL;
            OP_ADDC: begin
                ctl.fn   = FN_ADD;
                ctl.dual = 1'b1;
            end
            OP_LDI: begin
                ctl.fn      = FN_PASS;
                ctl.use_imm = 1'b1;
            end
            default: ctl.legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/belt_exec_alu.sv
// Module: belt_exec_alu
// Computes one of the ALU functions on two operands and also returns the
// carry out of the adder. Combinational. Shift amount is the low bits of B.
module belt_exec_alu
    import belt_exec_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  alu_fn_e            fn,
    input  logic [DATA_W-1:0]  opa,
    input  logic [DATA_W-1:0]  opb,
    output logic [DATA_W-1:0]  res,
    output logic               carry
);

    localparam int SH_W = $clog2(DATA_W);

    logic [DATA_W:0] sum_ext;

    // Wide adder shared by ADD and the carry-producing add
    always_comb sum_ext = {1'b0, opa} + {1'b0, opb};

    // Result selection by function
    always_comb begin
        carry = sum_ext[DATA_W];
        unique case (fn)
            FN_ADD:  res = sum_ext[DATA_W-1:0];
            FN_SUB:  res = opa - opb;
            FN_AND:  res = opa & opb;
            FN_OR:   res = opa | opb;
            FN_XOR:  res = opa ^ opb;
            FN_SHL:  res = opa << opb[SH_W-1:0];
            FN_PASS: res = opb;
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/belt_exec_drop.sv
// Module: belt_exec_drop
// Forms the drop port toward the belt store: one value, or a carry and a
// sum for the dual-result add. Assumes position 0 takes drop_val0.
module belt_exec_drop
    import belt_exec_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              fire,
    input  dec_ctl_t          ctl,
    input  logic [DATA_W-1:0] res,
    input  logic              carry,
    output logic              drop_valid,
    output logic [1:0]        drop_count,
    output logic [DATA_W-1:0] drop_val0,
    output logic [DATA_W-1:0] drop_val1
);

    // Drop count and value ordering
    always_comb begin
        drop_valid = fire && ctl.legal;
        drop_count = ctl.dual ? 2'd2 : 2'd1;
        drop_val0  = res;
        drop_val1  = ctl.dual ? {{(DATA_W-1){1'b0}}, carry} : '0;
    end

endmodule

// File: rtl/belt_exec_unit.sv
// Module: belt_exec_unit (top)
// Single-cycle execute stage of a belt processor. Reads two belt positions
// from an external store, computes, and drops results at the belt front in
// the acceptance cycle. Assumes the store reads combinationally and pushes
// drop_count values at the clock edge while drop_valid is high.
module belt_exec_unit
    import belt_exec_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int POS_W  = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic [OPC_W+2*POS_W-1:0]    in_instr,
    output logic [POS_W-1:0]            rd_pos_a,
    output logic [POS_W-1:0]            rd_pos_b,
    input  logic [DATA_W-1:0]           rd_data_a,
    input  logic [DATA_W-1:0]           rd_data_b,
    output logic                        drop_valid,
    output logic [1:0]                  drop_count,
    output logic [DATA_W-1:0]           drop_val0,
    output logic [DATA_W-1:0]           drop_val1,
    output logic                        illegal_flag
);

    localparam int IMM_W = 2 * POS_W;

    dec_ctl_t          ctl;
    logic [IMM_W-1:0]  imm;
    logic [DATA_W-1:0] opb;
    logic [DATA_W-1:0] alu_res;
    logic              alu_carry;
    logic              fire;
    logic              ready_q;
    logic              illegal_q;

    belt_exec_decode #(.POS_W(POS_W)) u_dec (
        .instr (in_instr),
        .pos_a (rd_pos_a),
        .pos_b (rd_pos_b),
        .imm   (imm),
        .ctl   (ctl)
    );

    // Operand B selection: belt value or sign-extended constant
    always_comb opb = ctl.use_imm ? {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm} : rd_data_b;

    belt_exec_alu #(.DATA_W(DATA_W)) u_alu (
        .fn    (ctl.fn),
        .opa   (rd_data_a),
        .opb   (opb),
        .res   (alu_res),
        .carry (alu_carry)
    );

    // Handshake completion
    always_comb fire = in_valid && ready_q;

    belt_exec_drop #(.DATA_W(DATA_W)) u_drop (
        .fire       (fire),
        .ctl        (ctl),
        .res        (alu_res),
        .carry      (alu_carry),
        .drop_valid (drop_valid),
        .drop_count (drop_count),
        .drop_val0  (drop_val0),
        .drop_val1  (drop_val1)
    );

    // Ready comes up one cycle after reset release
    always_ff @(posedge clk) begin
        if (!rst_n) ready_q <= 1'b0;
        else        ready_q <= 1'b1;
    end

    // Illegal flag tracks the last accepted instruction
    always_ff @(posedge clk) begin
        if (!rst_n)    illegal_q <= 1'b0;
        else if (fire) illegal_q <= !ctl.legal;
    end

    assign in_ready     = ready_q;
    assign illegal_flag = illegal_q;

endmodule

// File: rtl/belt_exec_chk.sv
// Module: belt_exec_chk
// Port-level properties for belt_exec_unit, attached with bind.
module belt_exec_chk #(
    parameter int DATA_W = 32,
    parameter int POS_W  = 5
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      in_valid,
    input logic                      in_ready,
    input logic [5+2*POS_W:0]        in_instr,
    input logic [DATA_W-1:0]         rd_data_a,
    input logic [DATA_W-1:0]         rd_data_b,
    input logic                      drop_valid,
    input logic [1:0]                drop_count,
    input logic [DATA_W-1:0]         drop_val0,
    input logic [DATA_W-1:0]         drop_val1,
    input logic                      illegal_flag
);

    localparam int IW = 6 + 2 * POS_W;

    logic [5:0] opc;
    logic       acc;
    logic       known;
    logic [DATA_W:0] wide_sum;

    always_comb begin
        opc      = in_instr[IW-1 -: 6];
        acc      = in_valid && in_ready;
        known    = opc inside {6'd1, 6'd2, 6'd3, 6'd4, 6'd5, 6'd6, 6'd8, 6'd16};
        wide_sum = {1'b0, rd_data_a} + {1'b0, rd_data_b};
    end

    a_r7_no_drop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |-> !drop_valid);

    a_r2_add_single: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && opc == 6'd1) |-> (drop_valid && drop_count == 2'd1
                                  && drop_val0 == wide_sum[DATA_W-1:0]));

    a_r4_addc_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && opc == 6'd8) |-> (drop_valid && drop_count == 2'd2
                                  && {drop_val1, drop_val0} == {{(DATA_W-1){1'b0}}, wide_sum}));

    a_r5_ldi_const: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && opc == 6'd16) |-> (drop_valid && drop_count == 2'd1
            && drop_val0 == {{(DATA_W-2*POS_W){in_instr[2*POS_W-1]}}, in_instr[2*POS_W-1:0]}));

    a_r6_illegal_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !known) |-> !drop_valid);

    a_r6_illegal_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !known) |=> illegal_flag);

    a_r6_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> $stable(illegal_flag));

    a_r8_ready_stays: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> in_ready);

endmodule

bind belt_exec_unit belt_exec_chk #(.DATA_W(DATA_W), .POS_W(POS_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_instr     (in_instr),
    .rd_data_a    (rd_data_a),
    .rd_data_b    (rd_data_b),
    .drop_valid   (drop_valid),
    .drop_count   (drop_count),
    .drop_val0    (drop_val0),
    .drop_val1    (drop_val1),
    .illegal_flag (illegal_flag)
);

// File: tb/tb_belt_exec_unit.sv
module tb_belt_exec_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_instr = '0;
    logic [4:0]  rd_pos_a, rd_pos_b;
    logic [31:0] rd_data_a, rd_data_b;
    logic        drop_valid;
    logic [1:0]  drop_count;
    logic [31:0] drop_val0, drop_val1;
    logic        illegal_flag;

    logic [31:0] belt [32];
    int n_chk = 0;
    int n_fail = 0;
    bit exp_ill = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    assign rd_data_a = belt[rd_pos_a];
    assign rd_data_b = belt[rd_pos_b];

    belt_exec_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_instr(in_instr), .rd_pos_a(rd_pos_a), .rd_pos_b(rd_pos_b),
        .rd_data_a(rd_data_a), .rd_data_b(rd_data_b), .drop_valid(drop_valid),
        .drop_count(drop_count), .drop_val0(drop_val0), .drop_val1(drop_val1),
        .illegal_flag(illegal_flag)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference behaviour from the requirements
    function automatic void model(input logic [15:0] ins, input logic [31:0] a, input logic [31:0] b,
                                  output bit legal, output int cnt,
                                  output logic [31:0] v0, output logic [31:0] v1);
        logic [32:0] s;
        s = {1'b0, a} + {1'b0, b};
        legal = 1'b1; cnt = 1; v1 = '0; v0 = '0;
        case (ins[15:10])
            6'd1:  v0 = a + b;
            6'd2:  v0 = a - b;
            6'd3:  v0 = a & b;
            6'd4:  v0 = a | b;
            6'd5:  v0 = a ^ b;
            6'd6:  v0 = a << b[4:0];
            6'd8:  begin cnt = 2; v0 = s[31:0]; v1 = {31'd0, s[32]}; end
            6'd16: v0 = {{22{ins[9]}}, ins[9:0]};
            default: begin legal = 1'b0; cnt = 0; end
        endcase
    endfunction

    function automatic logic [15:0] mk(input int opc, input int pa, input int pb);
        return {opc[5:0], pa[4:0], pb[4:0]};
    endfunction

    // Present one instruction, check drops, commit to the bench belt
    task automatic issue(input logic [15:0] ins, input bit v);
        bit lg; int cnt; logic [31:0] v0, v1;
        @(negedge clk);
        in_valid = v; in_instr = ins;
        #1;
        model(ins, belt[ins[9:5]], belt[ins[4:0]], lg, cnt, v0, v1);
        check(rd_pos_a == ins[9:5] && rd_pos_b == ins[4:0], "R1 position fields",
              {22'd0, rd_pos_a, rd_pos_b}, {22'd0, ins[9:0]});
        if (!v)
            check(!drop_valid, "R7 no drop without valid", {31'd0, drop_valid}, 0);
        else if (!lg)
            check(!drop_valid, "R6 undefined opcode drops nothing", {31'd0, drop_valid}, 0);
        else begin
            check(drop_valid && drop_count == cnt[1:0], "R2 R3 R4 R5 drop count",
                  {30'd0, drop_count}, cnt);
            check(drop_val0 == v0, "R2 R3 R4 R5 value at position 0", drop_val0, v0);
            if (cnt == 2)
                check(drop_val1 == v1, "R4 carry at position 1", drop_val1, v1);
        end
        @(posedge clk);
        #1;
        if (v) begin
            exp_ill = !lg;
            if (lg) begin
                for (int i = 31; i >= 0; i--)
                    if (i >= cnt) belt[i] = belt[i-cnt];
                belt[0] = v0;
                if (cnt == 2) belt[1] = v1;
            end
        end
        check(illegal_flag == exp_ill, "R6 illegal flag", {31'd0, illegal_flag}, {31'd0, exp_ill});
    endtask

    function automatic logic [15:0] rand_instr();
        int sel;
        int legal_ops [8] = '{1, 2, 3, 4, 5, 6, 8, 16};
        int opc;
        sel = $urandom_range(0, 9);
        if (sel < 8) opc = legal_ops[sel];
        else begin
            opc = $urandom_range(0, 63);
            while (opc inside {1, 2, 3, 4, 5, 6, 8, 16}) opc = $urandom_range(0, 63);
        end
        return mk(opc, $urandom_range(0, 31), $urandom_range(0, 31));
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_b17));
        for (int i = 0; i < 32; i++) belt[i] = $urandom();
        // R8: reset state, even with a valid instruction presented
        in_valid = 1'b1; in_instr = mk(1, 0, 1);
        repeat (3) @(posedge clk);
        #1;
        check(!in_ready, "R8 ready low in reset", {31'd0, in_ready}, 0);
        check(!drop_valid, "R8 no drop in reset", {31'd0, drop_valid}, 0);
        check(!illegal_flag, "R8 flag low in reset", {31'd0, illegal_flag}, 0);
        @(negedge clk); in_valid = 1'b0; rst_n = 1'b1;
        @(posedge clk); #1;
        check(in_ready, "R8 ready after reset", {31'd0, in_ready}, 1);

        // Directed corner cases
        belt[3] = 32'hFFFF_FFFF; belt[4] = 32'h0000_0001;
        issue(mk(8, 3, 4), 1'b1);            // R4 carry out, zero sum
        issue(mk(1, 1, 0), 1'b1);            // R9: reads sum at 0 and carry at 1
        check(belt[0] == 32'd1, "R9 next instruction sees both drops", belt[0], 1);
        issue(mk(16, 16, 0), 1'b1);          // R5 most negative constant
        check(belt[0] == 32'hFFFF_FE00, "R5 negative immediate", belt[0], 32'hFFFF_FE00);
        issue(mk(16, 15, 31), 1'b1);         // R5 most positive constant
        check(belt[0] == 32'd511, "R5 positive immediate", belt[0], 511);
        issue(mk(16, 0, 5), 1'b1);
        issue(mk(16, 0, 7), 1'b1);
        issue(mk(2, 1, 0), 1'b1);            // R2 SUB 5-7 wraps
        check(belt[0] == 32'hFFFF_FFFE, "R2 sub wraps", belt[0], 32'hFFFF_FFFE);
        issue(mk(6, 3, 0), 1'b1);            // R3 SHL by low 5 bits of B
        issue(mk(1, 0, 1), 1'b0);            // R7 idle cycle
        issue(mk(0, 2, 2), 1'b1);            // R6 undefined opcode 0
        issue(mk(8, 0, 1), 1'b1);            // R6 R4 flag clears during dual drop
        issue(mk(63, 0, 0), 1'b1);           // R6 undefined opcode 63
        issue(mk(1, 0, 1), 1'b0);            // R6 flag held across idle
        issue(mk(3, 0, 1), 1'b1);

        // Random stream
        for (int n = 0; n < 400; n++)
            issue(rand_instr(), ($urandom_range(0, 7) != 0));

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule